// File: doc/BRIEF.md
# NAND Flash Host Register Interface

This block sits between a processor's byte-wide register bus and a raw NAND flash device. Software first opens an operational window through a small configuration space: a command byte that carries a window-enable bit, and a 32-bit window base that is loaded one byte at a time. Once the window is open, accesses whose upper address bits match the base reach a handful of operational registers. These are a data port, a mode byte, a status byte, and an interrupt status and mask pair.

The mode byte drives the flash control pins directly. Command-latch, address-latch and write-protect follow their bits, and the chip enable is driven low when its bit is set. Two further mode bits tell a neighbouring ECC engine what to do. Data-port writes present a byte to the flash together with a one-cycle strobe. Data-port reads return the byte the flash drives. A single interrupt line needs two things: a master-enable bit in the mask, and a pending status bit that is also unmasked. It is recomputed only when software writes the data port, the mode byte or the mask.

Top module: `nand_host_if`

## Requirements
- R1: After reset the window is disabled and the base is zero. CLE, ALE and WP are low, the active-low chip enable is high, the ECC action is 00, and the interrupt is low.
- R2: Config offset 0x04 is the command byte. Its bit 1 opens the window, and the other bits are ignored. A read returns 0x02 when the window is open and 0x00 when it is closed.
- R3: Config offsets 0x10, 0x11, 0x12 and 0x13 hold base bits 7:0, 15:8, 23:16 and 31:24. Each byte is written on its own and can be read back.
- R4: An operational access is decoded only when the window is open and the address, with its low 8 bits forced to zero, equals the base. Any other operational write changes nothing, and any other operational read returns 0x00.
- R5: Mode byte (operational offset 0x04): bit 0 drives CLE, bit 1 drives ALE and bit 7 drives WP. The chip-enable pin is low exactly when bit 4 is set. Pins change on the clock edge that accepts the write, and the byte reads back.
- R6: Mode bits 6:5 appear on the ECC action output. The codes are 00 idle, 01 enable, 10 read-out and 11 reset.
- R7: A write to operational offset 0x00 puts the byte on the flash data output. The flash write strobe is high for the one cycle after the accepting edge.
- R8: A read of offset 0x00 returns the flash input byte as sampled in the read cycle. A read of offset 0x05 returns the flash ready level in bit 0 and zeros elsewhere.
- R9: The interrupt is registered. A write to offset 0x00, 0x04 or 0x07 sets it to (mask bit 7) AND (mask AND status is non-zero), using the values the write produces. At all other times it holds.
- R10: Interrupt status (offset 0x06) bit 0 is set by a rising edge of flash ready. Writing 1 to a status bit clears it, and a set in the same cycle wins. A status change alone does not re-evaluate the interrupt. The mask (offset 0x07) reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write request |
| bus_rd | input | 1 | Byte read request |
| bus_cfg | input | 1 | 1 selects configuration space, 0 the operational window |
| bus_addr | input | 32 | Byte address (config uses the low 8 bits) |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after the read |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_wp | output | 1 | Write protect level |
| nf_dout | output | 8 | Byte to the flash |
| nf_dout_we | output | 1 | One-cycle write strobe for nf_dout |
| nf_din | input | 8 | Byte from the flash |
| nf_ready | input | 1 | Flash ready level |
| ecc_op | output | 2 | ECC action code from the mode byte |
| irq | output | 1 | Interrupt request |

## Verification
Every result is one register stage away from its stimulus. A write changes the pins, the data strobe and the interrupt on the edge that accepts it, and read data appears on the edge that samples the read. A ready rise shows up in interrupt status one edge after the level goes high. The bench drives on falling edges and checks pins and the interrupt on the falling edge right after the accepting edge. Expected read bytes go into a queue when the read is issued. A monitor pops them on the falling edge after the read is sampled, so a value is never compared a cycle early or late.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;

    localparam int BYTE_W = 8;

    // operational window offsets
    localparam logic [7:0] OFS_DATA   = 8'h00;
    localparam logic [7:0] OFS_MODE   = 8'h04;
    localparam logic [7:0] OFS_STAT   = 8'h05;
    localparam logic [7:0] OFS_ISR    = 8'h06;
    localparam logic [7:0] OFS_MASK   = 8'h07;

    // configuration space offsets
    localparam logic [7:0] CFG_CMD    = 8'h04;
    localparam logic [7:0] CFG_BASE0  = 8'h10;

    typedef enum logic [1:0] {
        ECC_IDLE    = 2'b00,
        ECC_RUN     = 2'b01,
        ECC_READOUT = 2'b10,
        ECC_CLEAR   = 2'b11
    } ecc_act_e;

    typedef struct packed {
        logic     wp;     // 7
        ecc_act_e ecc;    // 6:5
        logic     ce;     // 4
        logic [1:0] spare;// 3:2
        logic     ale;    // 1
        logic     cle;    // 0
    } mode_t;

    typedef struct packed {
        logic wr_data;
        logic wr_mode;
        logic wr_isr;
        logic wr_mask;
        logic rd_data;
    } op_dec_t;

    function automatic op_dec_t decode_op(input logic hit, input logic wr,
                                          input logic rd, input logic [7:0] ofs);
        op_dec_t d;
        d.wr_data = hit && wr && (ofs == OFS_DATA);
        d.wr_mode = hit && wr && (ofs == OFS_MODE);
        d.wr_isr  = hit && wr && (ofs == OFS_ISR);
        d.wr_mask = hit && wr && (ofs == OFS_MASK);
        d.rd_data = hit && rd && (ofs == OFS_DATA);
        return d;
    endfunction

endpackage

// File: rtl/nand_cfg_space.sv
module nand_cfg_space
    import nand_host_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [7:0]        ofs,
    input  logic [7:0]        wdata,
    output logic              win_en,
    output logic [ADDR_W-1:0] base,
    output logic [7:0]        rd_byte
);
    localparam int NLANES = ADDR_W / BYTE_W;

    logic [7:0] lane_rd [NLANES];

    always_ff @(posedge clk) begin
        if (rst)                       win_en <= 1'b0;
        else if (wr && ofs == CFG_CMD) win_en <= wdata[1];
    end

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                base[g*BYTE_W +: BYTE_W] <= '0;
            else if (wr && ofs == CFG_BASE0 + 8'(g))
                base[g*BYTE_W +: BYTE_W] <= wdata;
        end
        assign lane_rd[g] = base[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        rd_byte = '0;
        if (ofs == CFG_CMD) rd_byte = {6'b0, win_en, 1'b0};
        for (int i = 0; i < NLANES; i++)
            if (ofs == CFG_BASE0 + 8'(i)) rd_byte = lane_rd[i];
    end

endmodule

// File: rtl/nand_pin_ctrl.sv
module nand_pin_ctrl
    import nand_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_mode,
    input  logic       wr_data,
    input  logic [7:0] wdata,
    output mode_t      mode_q,
    output logic [7:0] dout,
    output logic       dout_we
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            dout    <= '0;
            dout_we <= 1'b0;
        end else begin
            if (wr_mode) mode_q <= mode_t'(wdata);
            if (wr_data) dout <= wdata;
            dout_we <= wr_data;
        end
    end

    assert_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> (dout_we && dout == $past(wdata)));

    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_mode |=> $stable(mode_q));

endmodule

// File: rtl/nand_irq_ctrl.sv
module nand_irq_ctrl (
    input  logic       clk,
    input  logic       rst,
    input  logic       ready,
    input  logic       wr_isr,
    input  logic       wr_mask,
    input  logic       eval,
    input  logic [7:0] wdata,
    output logic [7:0] isr,
    output logic [7:0] imr,
    output logic       irq
);
    logic       rdy_q;
    logic       rise;
    logic [7:0] isr_nx;
    logic [7:0] imr_nx;

    assign rise   = ready && !rdy_q;
    assign isr_nx = (isr & ~(wr_isr ? wdata : 8'h00)) | {7'b0, rise};
    assign imr_nx = wr_mask ? wdata : imr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q <= 1'b0;
            isr   <= '0;
            imr   <= '0;
            irq   <= 1'b0;
        end else begin
            rdy_q <= ready;
            isr   <= isr_nx;
            imr   <= imr_nx;
            if (eval) irq <= imr_nx[7] && |(imr_nx & isr_nx);
        end
    end

    assert_ready_sets_R10: assert property (@(posedge clk) disable iff (rst)
        (ready && !rdy_q) |=> isr[0]);

    assert_master_gate_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> imr[7]);

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !eval |=> $stable(irq));

endmodule

// File: rtl/nand_host_if.sv
module nand_host_if
    import nand_host_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_cfg,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_ce_n,
    output logic              nf_wp,
    output logic [7:0]        nf_dout,
    output logic              nf_dout_we,
    input  logic [7:0]        nf_din,
    input  logic              nf_ready,
    output logic [1:0]        ecc_op,
    output logic              irq
);
    logic              win_en;
    logic [ADDR_W-1:0] base;
    logic [7:0]        cfg_rd;
    logic [7:0]        ofs;
    logic              win_hit;
    op_dec_t           dec;
    mode_t             mode_q;
    logic [7:0]        isr;
    logic [7:0]        imr;
    logic [7:0]        op_rd;

    assign ofs     = bus_addr[7:0];
    assign win_hit = !bus_cfg && win_en &&
                     ({bus_addr[ADDR_W-1:WIN_BITS], {WIN_BITS{1'b0}}} == base);
    assign dec     = decode_op(win_hit, bus_wr, bus_rd, ofs);

    nand_cfg_space #(.ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst(rst), .wr(bus_wr && bus_cfg), .ofs(ofs),
        .wdata(bus_wdata), .win_en(win_en), .base(base), .rd_byte(cfg_rd)
    );

    nand_pin_ctrl u_pins (
        .clk(clk), .rst(rst), .wr_mode(dec.wr_mode), .wr_data(dec.wr_data),
        .wdata(bus_wdata), .mode_q(mode_q), .dout(nf_dout), .dout_we(nf_dout_we)
    );

    nand_irq_ctrl u_irq (
        .clk(clk), .rst(rst), .ready(nf_ready), .wr_isr(dec.wr_isr),
        .wr_mask(dec.wr_mask), .eval(dec.wr_data || dec.wr_mode || dec.wr_mask),
        .wdata(bus_wdata), .isr(isr), .imr(imr), .irq(irq)
    );

    assign nf_cle  = mode_q.cle;
    assign nf_ale  = mode_q.ale;
    assign nf_ce_n = !mode_q.ce;
    assign nf_wp   = mode_q.wp;
    assign ecc_op  = mode_q.ecc;

    always_comb begin
        op_rd = '0;
        if (win_hit) begin
            case (ofs)
                OFS_DATA: op_rd = nf_din;
                OFS_MODE: op_rd = mode_q;
                OFS_STAT: op_rd = {7'b0, nf_ready};
                OFS_ISR:  op_rd = isr;
                OFS_MASK: op_rd = imr;
                default:  op_rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= bus_cfg ? cfg_rd : op_rd;
    end

    assert_ce_inverted_R5: assert property (@(posedge clk) disable iff (rst)
        dec.wr_mode |=> (nf_ce_n == !$past(bus_wdata[4])));

    assert_closed_window_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_cfg && !win_en) |=> $stable({nf_cle, nf_ale, nf_ce_n, nf_wp, ecc_op}));

    assert_cmd_read_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_cfg && ofs == CFG_CMD) |=> (bus_rdata == {6'b0, $past(win_en), 1'b0}));

endmodule

// File: tb/test_nand_host_if.sv
module test_nand_host_if;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_cfg = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        nf_cle, nf_ale, nf_ce_n, nf_wp, nf_dout_we, irq;
    logic [7:0]  nf_dout;
    logic [7:0]  nf_din = '0;
    logic        nf_ready = 1'b0;
    logic [1:0]  ecc_op;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic pend = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    localparam logic [31:0] BASE = 32'hA012_3400;

    always #10 clk = ~clk;

    nand_host_if i_nand_host_if (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_cfg(bus_cfg),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_ce_n(nf_ce_n), .nf_wp(nf_wp),
        .nf_dout(nf_dout), .nf_dout_we(nf_dout_we), .nf_din(nf_din),
        .nf_ready(nf_ready), .ecc_op(ecc_op), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic cfg, input logic [31:0] a, input logic [7:0] d);
        bus_cfg = cfg; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic cfg, input logic [31:0] a, input logic [7:0] e, input string tag);
        bus_cfg = cfg; bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: read data is due one edge after the read is sampled
    always @(posedge clk) pend <= bus_rd;
    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) chk("monitor underflow", 1, 0);
            else chk(tag_q.pop_front(), {24'b0, bus_rdata}, {24'b0, exp_q.pop_front()});
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pins", {nf_cle, nf_ale, nf_ce_n, nf_wp}, 4'b0010);
        chk("R1 ecc", ecc_op, 2'b00);
        chk("R1 irq", irq, 0);
        rd(1, 32'h04, 8'h00, "R1 R2 cmd closed");
        rd(1, 32'h10, 8'h00, "R1 R3 base zero");
        // R4 closed window ignores writes
        wr(0, 32'h0000_0004, 8'h13);
        chk("R4 closed write", {nf_cle, nf_ce_n}, 2'b01);
        // R3 base bytes
        wr(1, 32'h10, 8'h00);
        wr(1, 32'h11, 8'h34);
        wr(1, 32'h12, 8'h12);
        wr(1, 32'h13, 8'hA0);
        rd(1, 32'h11, 8'h34, "R3 lane1");
        rd(1, 32'h13, 8'hA0, "R3 lane3");
        // R2 enable bit only
        wr(1, 32'h04, 8'hFD);
        rd(1, 32'h04, 8'h00, "R2 bit1 clear");
        wr(1, 32'h04, 8'h02);
        rd(1, 32'h04, 8'h02, "R2 open");
        // R5 pins
        wr(0, BASE + 4, 8'h93);
        chk("R5 pins", {nf_cle, nf_ale, nf_ce_n, nf_wp}, 4'b1101);
        chk("R6 idle", ecc_op, 2'b00);
        // R6 ecc codes
        wr(0, BASE + 4, 8'h20);
        chk("R6 enable", ecc_op, 2'b01);
        chk("R5 ce off", {nf_cle, nf_ale, nf_ce_n, nf_wp}, 4'b0010);
        wr(0, BASE + 4, 8'h40);
        chk("R6 readout", ecc_op, 2'b10);
        wr(0, BASE + 4, 8'h60);
        chk("R6 reset", ecc_op, 2'b11);
        rd(0, BASE + 4, 8'h60, "R5 mode readback");
        // R4 wrong base
        wr(0, BASE + 32'h104, 8'h01);
        chk("R4 mismatch write", {nf_cle, ecc_op}, 3'b011);
        rd(0, BASE + 32'h104, 8'h00, "R4 mismatch read");
        // R7 data write
        wr(0, BASE, 8'h5A);
        chk("R7 strobe", nf_dout_we, 1);
        chk("R7 byte", nf_dout, 8'h5A);
        @(negedge clk);
        chk("R7 strobe one cycle", nf_dout_we, 0);
        // R8 data read and status
        nf_din = 8'hC3;
        rd(0, BASE, 8'hC3, "R8 data read");
        rd(0, BASE + 5, 8'h00, "R8 status low");
        nf_ready = 1'b1;
        @(negedge clk);
        rd(0, BASE + 5, 8'h01, "R8 status high");
        // R10 ready edge sets status, no re-evaluation
        rd(0, BASE + 6, 8'h01, "R10 isr set");
        chk("R10 no eval", irq, 0);
        // R9 master enable
        wr(0, BASE + 7, 8'h01);
        chk("R9 no master", irq, 0);
        wr(0, BASE + 7, 8'h81);
        chk("R9 master set", irq, 1);
        rd(0, BASE + 7, 8'h81, "R10 mask readback");
        // R10 write-1-clear does not re-evaluate
        wr(0, BASE + 6, 8'h01);
        chk("R10 clear holds irq", irq, 1);
        rd(0, BASE + 6, 8'h00, "R10 isr cleared");
        wr(0, BASE + 4, 8'h00);
        chk("R9 mode write eval", irq, 0);
        nf_ready = 1'b0;
        @(negedge clk);
        nf_ready = 1'b1;
        @(negedge clk);
        chk("R10 rise no eval", irq, 0);
        wr(0, BASE, 8'h11);
        chk("R9 data write eval", irq, 1);
        repeat (2) @(negedge clk);
        chk("queue drained", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule